// File: doc/BRIEF.md
# USB Receive Event and Mask Register

This block collects the receive-side events of a USB device controller that has several receive FIFOs. It holds two kinds of sticky flag for each FIFO. A packet flag records that a packet has finished or has failed. An overrun flag records that the FIFO overflowed. Both kinds of flag are visible in one read-only event register on a byte-wide register port.

The two kinds of flag clear in different ways. Packet flags clear when firmware reads that FIFO's own receive status register, which lives outside this block and is signalled here by a strobe. Overrun flags clear when firmware reads the event register itself.

A read/write mask register has the same layout as the event register. The block ORs the masked event bits into a single summary output, which feeds the controller's main event register.

Top module: `usb_rx_event_reg`

## Requirements
- R1: After reset, the event register, the mask register and the summary output are all zero.
- R2: For FIFOs 1 to 3, a packet-complete strobe or an error strobe sets that FIFO's packet flag, which is event bit i (bits 3:0 hold packet flags for FIFO 0..3).
- R3: For FIFO 0, only the packet-complete strobe sets the packet flag (bit 0). An error strobe alone leaves it unchanged.
- R4: A status-read strobe for FIFO i clears packet flag i on the following clock edge and leaves every other flag unchanged.
- R5: An overrun strobe for FIFO i sets event bit 4+i. A read of the event register (reg_sel = 0 with reg_rd = 1) clears all four overrun flags and leaves the packet flags unchanged.
- R6: reg_rdata shows the selected register combinationally (reg_sel = 0 for event, 1 for mask). A read returns the flag values as they were before its own clear takes effect.
- R7: A write with reg_sel = 1 loads reg_wdata into the mask on the next edge. A write with reg_sel = 0 has no effect on any flag.
- R8: rx_ev_o is high exactly when some event bit and its mask bit are both set, and it follows the flags in the same cycle.
- R9: When a set condition and a clear for the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_done_i | input | 4 | Per-FIFO packet-complete (last byte) strobe |
| pkt_err_i | input | 4 | Per-FIFO receive error strobe |
| ovr_i | input | 4 | Per-FIFO overrun strobe |
| stat_rd_i | input | 4 | Per-FIFO receive status register read strobe |
| reg_sel | input | 1 | Register select: 0 event, 1 mask |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Selected register contents |
| rx_ev_o | output | 1 | Masked summary of receive events |

## Verification
The assertions check the following on every cycle:
- each strobe sets its flag on the next edge;
- a clear with no set drops the flag;
- set wins over clear;
- FIFO 0 never takes a flag from an error alone;
- a mask write lands;
- the summary stays low while no flag is up.

Only the bench's scenarios can show the following:
- that a read returns the values from before its own clear;
- that a status read for one FIFO leaves the other FIFOs alone;
- that a write to the event register changes nothing;
- that the summary follows every mix of flags and mask.

The bench checks these against its own model under random and directed strobe patterns.

// File: rtl/rxev_pkg.sv
package rxev_pkg;
   typedef enum logic {
      SEL_EVENT = 1'b0,
      SEL_MASK  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/rxev_pkt_flag.sv
module rxev_pkt_flag #(
   parameter bit IGNORE_ERR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic err_i,
   input  logic clr_i,
   output logic flag_o
);
   logic set_c;
   logic flag_q;

   generate
      if (IGNORE_ERR) begin : g_done_only
         assign set_c = done_i;
         // R3: an error alone never raises the flag
         assert_err_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!done_i && !flag_q) |=> !flag_q);
      end else begin : g_done_or_err
         assign set_c = done_i | err_i;
         assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            err_i |=> flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_c)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_done_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> flag_q);
   assert_stat_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !done_i && !err_i) |=> !flag_q);
   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && done_i) |=> flag_q);
endmodule

// File: rtl/rxev_ovr_bank.sv
module rxev_ovr_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ovr_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] flag_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[i] <= 1'b0;
         else if (ovr_i[i]) flag_q[i] <= 1'b1;
         else if (clr_i)    flag_q[i] <= 1'b0;
      end

      assert_ovr_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
         ovr_i[i] |=> flag_q[i]);
      assert_ovr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !ovr_i[i]) |=> !flag_q[i]);
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/rxev_mask_reg.sv
module rxev_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '0;
      else if (we_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mask_q == $past(wdata_i)));
endmodule

// File: rtl/usb_rx_event_reg.sv
module usb_rx_event_reg #(
   parameter int                 NUM_FIFO   = 4,
   parameter int                 REG_W      = 8,
   parameter logic [NUM_FIFO-1:0] ERR_IGNORE = 4'b0001
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_FIFO-1:0] pkt_done_i,
   input  logic [NUM_FIFO-1:0] pkt_err_i,
   input  logic [NUM_FIFO-1:0] ovr_i,
   input  logic [NUM_FIFO-1:0] stat_rd_i,
   input  logic                reg_sel,
   input  logic                reg_rd,
   input  logic                reg_wr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                rx_ev_o
);
   import rxev_pkg::*;

   localparam int EV_W = 2 * NUM_FIFO;

   generate
      if (EV_W != REG_W) begin : g_bad_width
         $error("REG_W must equal twice NUM_FIFO");
      end
      if (NUM_FIFO < 1) begin : g_bad_count
         $error("NUM_FIFO must be at least one");
      end
   endgenerate

   logic [NUM_FIFO-1:0] pkt_flag;
   logic [NUM_FIFO-1:0] ovr_flag;
   logic [REG_W-1:0]    ev_q;
   logic [REG_W-1:0]    mask_q;
   logic                ev_read;
   logic                mask_we;

   assign ev_read = reg_rd && (reg_sel_e'(reg_sel) == SEL_EVENT);
   assign mask_we = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);

   for (genvar i = 0; i < NUM_FIFO; i++) begin : g_pkt
      rxev_pkt_flag #(
         .IGNORE_ERR (ERR_IGNORE[i])
      ) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .done_i (pkt_done_i[i]),
         .err_i  (pkt_err_i[i]),
         .clr_i  (stat_rd_i[i]),
         .flag_o (pkt_flag[i])
      );
   end

   rxev_ovr_bank #(
      .N (NUM_FIFO)
   ) u_ovr (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovr_i  (ovr_i),
      .clr_i  (ev_read),
      .flag_o (ovr_flag)
   );

   rxev_mask_reg #(
      .W (REG_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mask_we),
      .wdata_i (reg_wdata),
      .mask_o  (mask_q)
   );

   assign ev_q      = {ovr_flag, pkt_flag};
   assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_MASK) ? mask_q : ev_q;
   assign rx_ev_o   = |(ev_q & mask_q);

   assert_quiet_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_q == '0) |-> !rx_ev_o);
   assert_reset_zero_R1: assert property (@(posedge clk)
      !rst_n |-> (ev_q == '0 && mask_q == '0));
endmodule

// File: tb/usb_rx_event_reg_tb.sv
module usb_rx_event_reg_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] done = '0, err = '0, ovr = '0, srd = '0;
   logic       sel = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rx_ev;

   logic [7:0] ev_m = '0, mask_m = '0;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   usb_rx_event_reg u_dut (
      .clk(clk), .rst_n(rst_n), .pkt_done_i(done), .pkt_err_i(err),
      .ovr_i(ovr), .stat_rd_i(srd), .reg_sel(sel), .reg_rd(rd),
      .reg_wr(wr), .reg_wdata(wdata), .reg_rdata(rdata), .rx_ev_o(rx_ev)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] next_ev(input logic [7:0] cur);
      logic [7:0] n = cur;
      for (int i = 0; i < 4; i++) begin
         if (done[i] || (err[i] && i != 0)) n[i] = 1'b1;
         else if (srd[i])                   n[i] = 1'b0;
         if (ovr[i])                        n[4+i] = 1'b1;
         else if (rd && !sel)               n[4+i] = 1'b0;
      end
      return n;
   endfunction

   // one cycle: inputs already driven after a negedge
   task automatic cycle(input string req);
      #1;
      chk({7'd0, rx_ev}, {7'd0, |(ev_m & mask_m)}, "R8");
      if (rd) chk(rdata, sel ? mask_m : ev_m, req);
      ev_m = next_ev(ev_m);
      if (wr && sel) mask_m = wdata;
      @(negedge clk);
      done = '0; err = '0; ovr = '0; srd = '0; rd = 0; wr = 0;
   endtask

   task automatic read_reg(input logic s, input string req);
      sel = s; rd = 1; cycle(req);
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      // R1 reset state
      sel = 0; #1 chk(rdata, 8'h00, "R1");
      sel = 1; #1 chk(rdata, 8'h00, "R1");
      chk({7'd0, rx_ev}, 8'h00, "R1");
      rst_n = 1;
      @(negedge clk);
      // R3: error alone on FIFO 0
      err = 4'b0001; cycle("R3");
      read_reg(0, "R3"); chk(ev_m, 8'h00, "R3");
      done = 4'b0001; cycle("R3");
      sel = 0; #1 chk(rdata, 8'h01, "R3");
      // R2: error on FIFO 2
      err = 4'b0100; cycle("R2");
      sel = 0; #1 chk(rdata, 8'h05, "R2");
      // R4: status read of FIFO 2
      srd = 4'b0100; cycle("R4");
      sel = 0; #1 chk(rdata, 8'h01, "R4");
      // R5/R6: overruns then event read returns pre-clear value
      ovr = 4'b1010; cycle("R5");
      read_reg(0, "R6"); 
      sel = 0; #1 chk(rdata, 8'h01, "R5");
      // R7: write to event ignored, mask write lands
      sel = 0; wr = 1; wdata = 8'hFF; cycle("R7");
      sel = 0; #1 chk(rdata, 8'h01, "R7");
      sel = 1; wr = 1; wdata = 8'h5A; cycle("R7");
      read_reg(1, "R7"); chk(mask_m, 8'h5A, "R7");
      // R8 summary
      sel = 1; wr = 1; wdata = 8'h01; cycle("R8");
      #1 chk({7'd0, rx_ev}, 8'h01, "R8");
      @(negedge clk);
      sel = 1; wr = 1; wdata = 8'h00; cycle("R8");
      #1 chk({7'd0, rx_ev}, 8'h00, "R8");
      @(negedge clk);
      // R9: set and clear together
      srd = 4'b0010; done = 4'b0010; cycle("R9");
      ovr = 4'b0001; sel = 0; rd = 1; cycle("R9");
      sel = 0; #1 chk(rdata, 8'h13, "R9");
      // random phase
      for (int k = 0; k < 3000; k++) begin
         done  = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
         err   = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
         ovr   = ($urandom % 8 == 0) ? 4'($urandom) : 4'h0;
         srd   = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
         sel   = 1'($urandom);
         rd    = ($urandom % 3 == 0);
         wr    = ($urandom % 7 == 0);
         wdata = 8'($urandom);
         cycle("R6");
         read_reg(0, "R2");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule